// File: doc/BRIEF.md
# Phase-Frequency Detector with Windowed Lock

This block compares two single-cycle enable streams, one from the feedback divider and one from the reference divider. It reports which edge of each pair came first, and by how many system-clock cycles. While the feedback edge is ahead it raises `up`. While the reference edge is ahead it raises `dn`. Either pulse lasts exactly as many cycles as the gap between the two edges. A separate `drive_en` models the three-state driver. It is raised only once the gap has grown to at least the programmed window `win_cycles`. When the edges fall closer together than the window, the output stays released.

The block also has a registered active-low lock flag, `lock_n`. It is updated once per comparison, when the lagging edge arrives, and it is held until the next comparison ends. A synchronous `restart` abandons any comparison in progress so that both edges start again from a common point. It is used when a new division word is loaded.

The comparison runs in a three-state machine:
- `ST_IDLE`: waiting for the first edge of a pair.
- `ST_FB_LEAD`: the feedback edge has arrived and the block waits for the reference edge.
- `ST_REF_LEAD`: the reference edge has arrived and the block waits for the feedback edge.

The transitions are:
- `T_FB_FIRST`: from `ST_IDLE` to `ST_FB_LEAD`.
- `T_REF_FIRST`: from `ST_IDLE` to `ST_REF_LEAD`.
- `T_TIE`: `ST_IDLE` stays in `ST_IDLE` when both edges arrive together.
- `T_REF_LAG`: from `ST_FB_LEAD` to `ST_IDLE`.
- `T_FB_LAG`: from `ST_REF_LEAD` to `ST_IDLE`.
- `T_EXTEND`: a waiting state stays where it is when the same leading edge repeats.
- `T_RESTART`: from any state to `ST_IDLE`.

Top module: `pfd_lock`

## Requirements
- R1: During and after reset, before any edge, `up`, `dn` and `drive_en` are 0 and `lock_n` is 1.
- R2: A feedback edge seen in idle, followed by a reference edge e cycles later, makes `up` high for exactly e cycles. `up` rises in the cycle after the feedback edge and `dn` stays 0.
- R3: A reference edge seen in idle, followed by a feedback edge e cycles later, makes `dn` high for exactly e cycles. `dn` rises in the cycle after the reference edge and `up` stays 0.
- R4: `up` and `dn` are never high in the same cycle.
- R5: During a pulse, `drive_en` is high only in those cycles where the elapsed gap (1 in the first pulse cycle, counting up) is at least `win_cycles`. If the final gap is below `win_cycles`, `drive_en` never rises. `drive_en` is never high without a pulse.
- R6: When the lagging edge arrives with gap e, `lock_n` becomes 0 in the next cycle if e < `win_cycles` and 1 otherwise. It then holds until the next comparison ends, and it changes in no other cycle.
- R7: Both edges arriving in the same idle cycle count as gap 0. No pulse is produced, and `lock_n` becomes 0 unless `win_cycles` is 0.
- R8: A repeated leading edge that arrives before the lagging edge does not restart the measurement. The pulse width still counts from the first leading edge.
- R9: `restart` returns the block to idle. Any pulse ends in the next cycle, edges presented in the same cycle are ignored, and `lock_n` is unchanged.
- R10: The gap counter saturates at 2^WIN_W-1 (15 by default). Gaps at or above that value count as outside any window, and `drive_en` stays high for the rest of the pulse.
- R11: A lagging edge that arrives together with a repeat of the leading edge ends the comparison. The block returns to idle with no new pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Synchronous realignment, abandons a comparison |
| fb_pulse | input | 1 | One-cycle edge from the feedback divider |
| ref_pulse | input | 1 | One-cycle edge from the reference divider |
| win_cycles | input | WIN_W | Dead window in system-clock cycles |
| up | output | 1 | Feedback-ahead correction pulse |
| dn | output | 1 | Reference-ahead correction pulse |
| drive_en | output | 1 | Driver enable, low means released |
| lock_n | output | 1 | Active-low lock flag |

## Verification
`restart` and the arrival of a lagging edge can fall in the same cycle. Both would return the machine to idle, but only the lagging edge may update the lock flag. The bench provokes this case in two steps. First it drives a comparison far enough to move `lock_n` to a known level. It then presents `restart` together with the reference edge that would otherwise close the comparison. The result is judged on the cycle that follows: the pulse must have ended and `lock_n` must still hold its earlier level. A second check places `restart` on a fresh leading edge and confirms that no pulse starts.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FB_LEAD  = 2'd1,
        ST_REF_LEAD = 2'd2
    } cmp_state_t;

endpackage

// File: rtl/pfd_edge_fsm.sv
module pfd_edge_fsm
    import pfd_lock_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             fb_pulse,
    input  logic             ref_pulse,
    output cmp_state_t       state_q,
    output logic [CNT_W-1:0] gap_q,
    output logic             resolve,
    output logic [CNT_W-1:0] gap_final
);

    localparam logic [CNT_W-1:0] GAP_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] GAP_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cmp_state_t       state_d;
    logic [CNT_W-1:0] gap_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    // next state, gap count and resolution
    always_comb begin
        state_d   = state_q;
        gap_d     = gap_q;
        resolve   = 1'b0;
        gap_final = gap_q;
        if (restart) begin
            // T_RESTART
            state_d = ST_IDLE;
            gap_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    gap_d = '0;
                    if (fb_pulse && ref_pulse) begin
                        // T_TIE
                        resolve   = 1'b1;
                        gap_final = '0;
                    end else if (fb_pulse) begin
                        // T_FB_FIRST
                        state_d = ST_FB_LEAD;
                        gap_d   = GAP_ONE;
                    end else if (ref_pulse) begin
                        // T_REF_FIRST
                        state_d = ST_REF_LEAD;
                        gap_d   = GAP_ONE;
                    end
                end
                ST_FB_LEAD: begin
                    if (ref_pulse) begin
                        // T_REF_LAG (a coincident fb repeat is absorbed)
                        state_d = ST_IDLE;
                        gap_d   = '0;
                        resolve = 1'b1;
                    end else begin
                        // T_EXTEND or plain wait
                        gap_d = (gap_q == GAP_MAX) ? GAP_MAX : gap_q + GAP_ONE;
                    end
                end
                ST_REF_LEAD: begin
                    if (fb_pulse) begin
                        // T_FB_LAG
                        state_d = ST_IDLE;
                        gap_d   = '0;
                        resolve = 1'b1;
                    end else begin
                        gap_d = (gap_q == GAP_MAX) ? GAP_MAX : gap_q + GAP_ONE;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    gap_d   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pfd_lock_eval.sv
module pfd_lock_eval #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             resolve,
    input  logic [CNT_W-1:0] gap_final,
    input  logic [CNT_W-1:0] win_cycles,
    output logic             locked_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else if (resolve) begin
            locked_q <= (gap_final < win_cycles);
        end
    end

endmodule

// File: rtl/pfd_drive_gate.sv
module pfd_drive_gate
    import pfd_lock_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  cmp_state_t       state_q,
    input  logic [CNT_W-1:0] gap_q,
    input  logic [CNT_W-1:0] win_cycles,
    output logic             up,
    output logic             dn,
    output logic             drive_en
);

    // output process
    always_comb begin
        up       = 1'b0;
        dn       = 1'b0;
        drive_en = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FB_LEAD: begin
                up       = 1'b1;
                drive_en = (gap_q >= win_cycles);
            end
            ST_REF_LEAD: begin
                dn       = 1'b1;
                drive_en = (gap_q >= win_cycles);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pfd_lock.sv
module pfd_lock
    import pfd_lock_pkg::*;
#(
    parameter int WIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             fb_pulse,
    input  logic             ref_pulse,
    input  logic [WIN_W-1:0] win_cycles,
    output logic             up,
    output logic             dn,
    output logic             drive_en,
    output logic             lock_n
);

    cmp_state_t       state_q;
    logic [WIN_W-1:0] gap_q;
    logic [WIN_W-1:0] gap_final;
    logic             resolve;
    logic             locked_q;

    pfd_edge_fsm #(.CNT_W(WIN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .fb_pulse  (fb_pulse),
        .ref_pulse (ref_pulse),
        .state_q   (state_q),
        .gap_q     (gap_q),
        .resolve   (resolve),
        .gap_final (gap_final)
    );

    pfd_lock_eval #(.CNT_W(WIN_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .resolve    (resolve),
        .gap_final  (gap_final),
        .win_cycles (win_cycles),
        .locked_q   (locked_q)
    );

    pfd_drive_gate #(.CNT_W(WIN_W)) u_gate (
        .state_q    (state_q),
        .gap_q      (gap_q),
        .win_cycles (win_cycles),
        .up         (up),
        .dn         (dn),
        .drive_en   (drive_en)
    );

    assign lock_n = ~locked_q;

endmodule

// File: rtl/pfd_lock_checker.sv
module pfd_lock_checker #(
    parameter int WIN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic             fb_pulse,
    input logic             ref_pulse,
    input logic [WIN_W-1:0] win_cycles,
    input logic             up,
    input logic             dn,
    input logic             drive_en,
    input logic             lock_n
);

    AST_UP_DN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn)); // R4

    AST_DRIVE_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (up || dn)); // R5

    AST_RESTART_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!up && !dn)); // R9

    AST_RESTART_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> $stable(lock_n)); // R9

    AST_LOCK_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fb_pulse || ref_pulse) |=> $stable(lock_n)); // R6

    AST_UP_FOLLOWS_FB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up) |-> $past(fb_pulse)); // R2

    AST_DN_FOLLOWS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn) |-> $past(ref_pulse)); // R3

endmodule

bind pfd_lock pfd_lock_checker #(.WIN_W(WIN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .fb_pulse   (fb_pulse),
    .ref_pulse  (ref_pulse),
    .win_cycles (win_cycles),
    .up         (up),
    .dn         (dn),
    .drive_en   (drive_en),
    .lock_n     (lock_n)
);

// File: tb/pfd_lock_test.sv
`timescale 1ns/1ps
module pfd_lock_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       fb = 1'b0;
    logic       rf = 1'b0;
    logic [3:0] win = 4'd0;
    logic       up, dn, drive_en, lock_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pfd_lock #(.WIN_W(4)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .fb_pulse   (fb),
        .ref_pulse  (rf),
        .win_cycles (win),
        .up         (up),
        .dn         (dn),
        .drive_en   (drive_en),
        .lock_n     (lock_n)
    );

    // {lead[1:0] (0 fb, 1 ref, 2 tie), gap[5:0], window[3:0]}
    localparam int NV = 10;
    localparam logic [11:0] VEC [NV] = '{
        {2'd0, 6'd3,  4'd5},
        {2'd0, 6'd6,  4'd4},
        {2'd1, 6'd2,  4'd2},
        {2'd1, 6'd1,  4'd2},
        {2'd2, 6'd0,  4'd3},
        {2'd2, 6'd0,  4'd0},
        {2'd0, 6'd20, 4'd15},
        {2'd1, 6'd17, 4'd15},
        {2'd0, 6'd4,  4'd0},
        {2'd1, 6'd14, 4'd15}
    };

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_cmp(int lead, int gap, int w, string req);
        int upc = 0, dnc = 0, drc = 0, both = 0, want_dr = 0, gsat;
        @(negedge clk);
        win = 4'(w);
        fb = (lead != 1);
        rf = (lead != 0);
        @(negedge clk);
        fb = 0; rf = 0;
        for (int i = 0; i < gap; i++) begin
            upc += int'(up); dnc += int'(dn); drc += int'(drive_en);
            if (up && dn) both++;
            if (i == gap - 1) begin
                if (lead == 0) rf = 1; else fb = 1;
            end
            @(negedge clk);
            fb = 0; rf = 0;
        end
        upc += int'(up); dnc += int'(dn); drc += int'(drive_en);
        for (int c = 1; c <= gap; c++) begin
            if (((c > 15) ? 15 : c) >= w) want_dr++;
        end
        gsat = (gap > 15) ? 15 : gap;
        chk(req, "up width",  upc, (lead == 0) ? gap : 0);
        chk(req, "dn width",  dnc, (lead == 1) ? gap : 0);
        chk("R4", "overlap",  both, 0);
        chk("R5", "drive cycles", drc, want_dr);
        chk("R6", "lock_n", int'(lock_n), (gsat < w) ? 0 : 1);
    endtask

    initial begin
        #(200000 * 8);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int upc;
        int held;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "up in reset", int'(up), 0);
        chk("R1", "lock_n in reset", int'(lock_n), 1);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "dn after reset", int'(dn), 0);
        chk("R1", "drive_en after reset", int'(drive_en), 0);
        chk("R1", "lock_n after reset", int'(lock_n), 1);

        for (int v = 0; v < NV; v++) begin
            int lead = int'(VEC[v][11:10]);
            int gap  = int'(VEC[v][9:4]);
            int w    = int'(VEC[v][3:0]);
            string req = (gap > 15) ? "R10" : (lead == 2) ? "R7" : (lead == 0) ? "R2" : "R3";
            run_cmp(lead, gap, w, req);
        end

        // R8: repeated fb before ref, width counts from the first fb
        run_cmp(0, 6, 4, "R2");  // lock_n -> 1
        @(negedge clk);
        win = 4'd7; fb = 1;
        @(negedge clk);
        fb = 0;
        upc = 0;
        for (int i = 0; i < 8; i++) begin
            upc += int'(up);
            if (i == 1) fb = 1;
            if (i == 4) rf = 1;
            @(negedge clk);
            fb = 0; rf = 0;
        end
        chk("R8", "up width with repeat", upc, 5);
        chk("R8", "lock_n", int'(lock_n), 0);

        // R11: lagging ref together with repeat fb
        run_cmp(0, 6, 4, "R2");  // lock_n -> 1
        @(negedge clk);
        win = 4'd7; fb = 1;
        @(negedge clk);
        fb = 0;
        @(negedge clk);
        fb = 1; rf = 1;
        @(negedge clk);
        fb = 0; rf = 0;
        chk("R11", "up after coincident edges", int'(up), 0);
        chk("R11", "lock_n", int'(lock_n), 0);
        @(negedge clk);
        chk("R11", "no new pulse", int'(up), 0);

        // R9: restart in the same cycle as the lagging ref
        run_cmp(0, 6, 4, "R2");  // lock_n -> 1
        held = int'(lock_n);
        @(negedge clk);
        win = 4'd7; fb = 1;
        @(negedge clk);
        fb = 0;
        chk("R9", "up before restart", int'(up), 1);
        restart = 1; rf = 1;
        @(negedge clk);
        restart = 0; rf = 0;
        chk("R9", "up after restart", int'(up), 0);
        chk("R9", "lock_n held", int'(lock_n), held);
        restart = 1; fb = 1;
        @(negedge clk);
        restart = 0; fb = 0;
        chk("R9", "fb with restart ignored", int'(up), 0);
        chk("R9", "dn stays low", int'(dn), 0);
        @(negedge clk);
        chk("R9", "still idle", int'(up | dn), 0);
        chk("R9", "lock_n still held", int'(lock_n), held);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule